// File: doc/BRIEF.md
# Button Debounce and Long-Press Override Monitor

This block watches one active-low push button, such as a power or sleep button, and reports presses to a power-management event controller through sticky status bits. The raw pin is asynchronous, so it is first brought into the clock domain by a flop synchronizer. A debounce filter then accepts a new level only after that level has stayed unchanged for a whole window. The window is measured in ticks of a slow timebase input and is applied to both press and release. An extra-debounce control doubles the window. A press that the filter accepts sets the press status bit.

A long-press detector measures how long the filtered button has been held down. If it is held past a threshold and the override is not disabled, the press status is withdrawn and a separate override status bit is set. The hold measurement restarts each time the filtered level returns to released. The button function only operates while a function-select input is high. When it is low, the filter and the hold timer are held idle and no status can be set. Software clears each status bit by writing a one to its position; a write of zero leaves the bit unchanged. All pins are plain control and status signals. The block has no streaming interface, so it has no valid/ready handshake and no back-pressure.

Top module: `btn_debounce_monitor`

## Requirements
- R1: After reset both status outputs are 0.
- R2: The press status `evt_sts_o` is set when the synchronized button has been low, against a released filtered level, for DEB_TICKS consecutive `tick_i` pulses. After DEB_TICKS-1 such ticks it is still clear. The status only rises on the clock edge that samples a tick.
- R3: A low pulse that returns high before the window completes is ignored, and the window count restarts from zero.
- R4: Release is filtered the same way. A high blip shorter than the window, while the filtered level is pressed, does not count as a release, so the low level that follows produces no new press event.
- R5: With `dbl_deb_i` high the window is 2*DEB_TICKS ticks. After 2*DEB_TICKS-1 ticks no press is reported.
- R6: While `func_sel_i` is low, `evt_sts_o` never becomes set.
- R7: With `ovr_dis_i` low, on the (HOLD_TICKS+1)-th tick counted while the filtered level is pressed, `evt_sts_o` clears and `ovr_sts_o` sets on the same edge.
- R8: With `ovr_dis_i` high, holding does not set `ovr_sts_o`, and `evt_sts_o` stays set.
- R9: A write (`sw_wr_i` high) clears `evt_sts_o` when `sw_wdata_i[0]` is 1 and clears `ovr_sts_o` when `sw_wdata_i[1]` is 1. Zero bits have no effect. A hardware set in the same cycle wins over the clear.
- R10: The hold count restarts whenever the filtered level returns to released. Ticks held before a release do not add to the next press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse from the slow timebase (nominally every 4 ms) |
| btn_n_i | input | 1 | Raw asynchronous button, low = pressed |
| func_sel_i | input | 1 | High enables the button function |
| dbl_deb_i | input | 1 | High doubles the debounce window |
| ovr_dis_i | input | 1 | High disables the long-press override |
| sw_wr_i | input | 1 | Software write strobe for the status bits |
| sw_wdata_i | input | 2 | Write-one-to-clear data: bit 0 press status, bit 1 override status |
| evt_sts_o | output | 1 | Sticky press status |
| ovr_sts_o | output | 1 | Sticky long-press override status |

## Verification
Every cycle, the assertions check the following:
- the press status only rises on a tick and while the function is selected;
- the override status only rises with the override enabled and the press status cleared;
- an accepted long press moves the event between the two bits;
- write-one clears take effect and zero writes change nothing;
- press and override events never coincide.

The exact window lengths cannot be seen by a cycle property. Only the bench scenarios show them: the tick count at which a press is reported in normal and doubled mode, the rejection of short glitches in each direction, and the restart of the hold count after a release.

// File: rtl/btn_mon_pkg.sv
package btn_mon_pkg;
  // Bit positions of the write-one-to-clear data word
  localparam int STS_EVT_BIT = 0;
  localparam int STS_OVR_BIT = 1;
  localparam int STS_W       = 2;

  typedef struct packed {
    logic press;
    logic long_hold;
  } btn_evt_t;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/btn_filter.sv
module btn_filter #(
  parameter int DEB_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic tick_i,
  input  logic dbl_i,
  input  logic raw_i,
  output logic level_o,
  output logic press_p_o
);
  localparam int CNT_W = $clog2(2 * DEB_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             level_q;
  logic             differs;
  logic             done;

  assign limit   = dbl_i ? CNT_W'(2 * DEB_TICKS) : CNT_W'(DEB_TICKS);
  assign differs = (raw_i != level_q);
  assign done    = tick_i && differs && (cnt_q >= limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
    end else if (!enable_i) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
    end else if (!differs) begin
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (done) begin
        level_q <= raw_i;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign level_o   = level_q;
  assign press_p_o = enable_i && done && !raw_i;
endmodule

// File: rtl/btn_hold_timer.sv
module btn_hold_timer #(
  parameter int HOLD_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pressed_i,
  input  logic tick_i,
  input  logic ovr_dis_i,
  output logic long_p_o
);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [HW-1:0] cnt_q;
  logic          fired_q;
  logic          at_limit;

  assign at_limit = (cnt_q == HW'(HOLD_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (!pressed_i) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (tick_i) begin
      if (!at_limit) cnt_q   <= cnt_q + HW'(1);
      else           fired_q <= 1'b1;
    end
  end

  assign long_p_o = pressed_i && tick_i && at_limit && !fired_q && !ovr_dis_i;
endmodule

// File: rtl/btn_status_regs.sv
module btn_status_regs
  import btn_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  btn_evt_t         evt_i,
  input  logic             wr_i,
  input  logic [STS_W-1:0] wdata_i,
  output logic             evt_sts_o,
  output logic             ovr_sts_o
);
  logic clr_evt, clr_ovr;

  assign clr_evt = wr_i && wdata_i[STS_EVT_BIT];
  assign clr_ovr = wr_i && wdata_i[STS_OVR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_sts_o <= 1'b0;
      ovr_sts_o <= 1'b0;
    end else begin
      if (evt_i.long_hold)  evt_sts_o <= 1'b0;
      else if (evt_i.press) evt_sts_o <= 1'b1;
      else if (clr_evt)     evt_sts_o <= 1'b0;

      if (evt_i.long_hold)  ovr_sts_o <= 1'b1;
      else if (clr_ovr)     ovr_sts_o <= 1'b0;
    end
  end
endmodule

// File: rtl/btn_debounce_monitor.sv
module btn_debounce_monitor
  import btn_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_TICKS   = 4,
  parameter int HOLD_TICKS  = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             btn_n_i,
  input  logic             func_sel_i,
  input  logic             dbl_deb_i,
  input  logic             ovr_dis_i,
  input  logic             sw_wr_i,
  input  logic [STS_W-1:0] sw_wdata_i,
  output logic             evt_sts_o,
  output logic             ovr_sts_o
);
  logic     btn_sync_n;
  logic     deb_level;
  logic     press_p;
  logic     long_p;
  btn_evt_t events;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (btn_n_i),
    .sync_o  (btn_sync_n)
  );

  btn_filter #(.DEB_TICKS(DEB_TICKS)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (func_sel_i),
    .tick_i    (tick_i),
    .dbl_i     (dbl_deb_i),
    .raw_i     (btn_sync_n),
    .level_o   (deb_level),
    .press_p_o (press_p)
  );

  btn_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .pressed_i (!deb_level),
    .tick_i    (tick_i),
    .ovr_dis_i (ovr_dis_i),
    .long_p_o  (long_p)
  );

  assign events.press     = press_p;
  assign events.long_hold = long_p;

  btn_status_regs u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (events),
    .wr_i      (sw_wr_i),
    .wdata_i   (sw_wdata_i),
    .evt_sts_o (evt_sts_o),
    .ovr_sts_o (ovr_sts_o)
  );
endmodule

// File: rtl/btn_monitor_checker.sv
module btn_monitor_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       func_sel_i,
  input logic       ovr_dis_i,
  input logic       sw_wr_i,
  input logic [1:0] sw_wdata_i,
  input logic       press_p,
  input logic       long_p,
  input logic       evt_sts_o,
  input logic       ovr_sts_o
);
  assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_sts_o) |-> $past(tick_i));

  assert_rise_needs_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_sts_o) |-> $past(func_sel_i));

  assert_long_moves_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    long_p |=> (ovr_sts_o && !evt_sts_o));

  assert_ovr_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_sts_o) |-> (!$past(ovr_dis_i) && !evt_sts_o));

  assert_w1c_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && sw_wdata_i[0] && !press_p) |=> !evt_sts_o);

  assert_w1c_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && sw_wdata_i[1] && !long_p) |=> !ovr_sts_o);

  assert_w0_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && sw_wdata_i == 2'b00 && !press_p && !long_p) |=>
      ($stable(evt_sts_o) && $stable(ovr_sts_o)));

  assert_events_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(press_p && long_p));
endmodule

bind btn_debounce_monitor btn_monitor_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .func_sel_i (func_sel_i),
  .ovr_dis_i  (ovr_dis_i),
  .sw_wr_i    (sw_wr_i),
  .sw_wdata_i (sw_wdata_i),
  .press_p    (press_p),
  .long_p     (long_p),
  .evt_sts_o  (evt_sts_o),
  .ovr_sts_o  (ovr_sts_o)
);

// File: tb/btn_debounce_monitor_tb.sv
module btn_debounce_monitor_tb;
  localparam int DEB  = 4;
  localparam int HOLD = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       btn_n = 1'b1;
  logic       fsel = 1'b1;
  logic       dbl = 1'b0;
  logic       odis = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] wdata = 2'b00;
  logic       evt, ovr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  btn_debounce_monitor #(.SYNC_STAGES(2), .DEB_TICKS(DEB), .HOLD_TICKS(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .btn_n_i(btn_n),
    .func_sel_i(fsel), .dbl_deb_i(dbl), .ovr_dis_i(odis),
    .sw_wr_i(wr), .sw_wdata_i(wdata), .evt_sts_o(evt), .ovr_sts_o(ovr)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (7) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic set_btn(input logic v);
    @(negedge clk);
    btn_n = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic sw_write(input logic [1:0] d);
    @(negedge clk);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = 2'b00;
    @(negedge clk);
  endtask

  task automatic restore();
    set_btn(1'b1);
    ticks(2 * DEB);
    sw_write(2'b11);
  endtask

  task automatic t_reset();
    chk("R1 evt after reset", evt, 1'b0);
    chk("R1 ovr after reset", ovr, 1'b0);
  endtask

  task automatic t_press();
    set_btn(1'b0);
    ticks(DEB - 1);
    chk("R2 evt before window end", evt, 1'b0);
    ticks(1);
    chk("R2 evt at window end", evt, 1'b1);
    sw_write(2'b00);
    chk("R9 zero write keeps evt", evt, 1'b1);
    sw_write(2'b10);
    chk("R9 ovr-bit write keeps evt", evt, 1'b1);
    sw_write(2'b01);
    chk("R9 evt-bit write clears evt", evt, 1'b0);
    restore();
  endtask

  task automatic t_glitch_low();
    set_btn(1'b0);
    ticks(DEB - 1);
    set_btn(1'b1);
    ticks(1);
    set_btn(1'b0);
    ticks(DEB - 1);
    chk("R3 short low pulses ignored", evt, 1'b0);
    ticks(1);
    chk("R3 count restarted then completes", evt, 1'b1);
    restore();
  endtask

  task automatic t_glitch_high();
    set_btn(1'b0);
    ticks(DEB);
    sw_write(2'b01);
    set_btn(1'b1);
    ticks(DEB - 2);
    set_btn(1'b0);
    ticks(DEB + 2);
    chk("R4 short release blip gives no new press", evt, 1'b0);
    restore();
  endtask

  task automatic t_double();
    dbl = 1'b1;
    set_btn(1'b0);
    ticks(2 * DEB - 1);
    chk("R5 doubled window not yet done", evt, 1'b0);
    ticks(1);
    chk("R5 doubled window done", evt, 1'b1);
    dbl = 1'b0;
    restore();
  endtask

  task automatic t_nosel();
    fsel = 1'b0;
    set_btn(1'b0);
    ticks(2 * DEB);
    chk("R6 no status without function select", evt, 1'b0);
    set_btn(1'b1);
    fsel = 1'b1;
    restore();
  endtask

  task automatic t_long();
    set_btn(1'b0);
    ticks(DEB);
    ticks(HOLD);
    chk("R7 evt kept before threshold", evt, 1'b1);
    chk("R7 ovr clear before threshold", ovr, 1'b0);
    ticks(1);
    chk("R7 evt cleared past threshold", evt, 1'b0);
    chk("R7 ovr set past threshold", ovr, 1'b1);
    sw_write(2'b01);
    chk("R9 evt-bit write keeps ovr", ovr, 1'b1);
    sw_write(2'b10);
    chk("R9 ovr-bit write clears ovr", ovr, 1'b0);
    restore();
  endtask

  task automatic t_ovr_dis();
    odis = 1'b1;
    set_btn(1'b0);
    ticks(DEB + HOLD + 3);
    chk("R8 ovr stays clear when disabled", ovr, 1'b0);
    chk("R8 evt stays set when disabled", evt, 1'b1);
    odis = 1'b0;
    restore();
  endtask

  task automatic t_restart();
    set_btn(1'b0);
    ticks(DEB + 6);
    set_btn(1'b1);
    ticks(DEB);
    set_btn(1'b0);
    ticks(DEB + 10);
    chk("R10 hold count restarted after release", ovr, 1'b0);
    chk("R10 second press reported", evt, 1'b1);
    ticks(3);
    chk("R10 override after full hold from second press", ovr, 1'b1);
    restore();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_press();
    t_glitch_low();
    t_glitch_high();
    t_double();
    t_nosel();
    t_long();
    t_ovr_dis();
    t_restart();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule